// File: doc/BRIEF.md
# Router Operation Mailbox Engine

This block is the device side of a command mailbox that sits in a router's configuration space. Host software loads a metadata word and up to sixteen data dwords, then writes an opcode with its valid flag set. The engine stays busy for a fixed number of cycles and then carries out the operation in one step. It clears the valid flag and leaves either a status code or a not-supported flag for software to poll.

The operations cover a small word-addressed non-volatile store held in on-chip registers: reading it, loading a write pointer, writing from the data window while that pointer advances, asking for the sector size, and an image check. There is also a read-only descriptor table whose contents are computed, and one display input resource that adapters can query, claim and give back. All access goes through a synchronous register bus that returns read data one cycle after the request.

Top module: `opmbox_engine`

## Requirements
- R1: After reset the command register (address 17), the metadata register (address 16) and every data window dword (addresses 0 to 15) read as zero.
- R2: The command register holds the opcode in bits 15:0, the valid flag in bit 31, the not-supported flag in bit 30 and the status in bits 27:24. Writing it with bit 31 set starts an operation. Bit 31 then reads 1 for exactly BUSY_CYCLES+1 back-to-back polls before it reads 0. Bus read data appears the cycle after the request.
- R3: An opcode outside 0x10, 0x11, 0x12, 0x20, 0x21, 0x22, 0x23, 0x24 and 0x25 completes with the not-supported flag set and status 0. Every listed opcode completes with the flag clear.
- R4: Read (0x22) takes a dword offset from metadata bits 23:2 and a count from bits 27:24, where 0 means 16. It copies that many stored dwords into window slots 0 upward, leaves the other slots unchanged and returns status 0.
- R5: A read or write that would reach past NVM_DWORDS returns status 1 and leaves the window, the store and the write pointer unchanged.
- R6: Set-offset (0x23) loads the write pointer from metadata bits 23:2. An offset of NVM_DWORDS or more returns status 1 and keeps the old pointer.
- R7: Write (0x20) stores window slots 0 to n-1 at the write pointer, where n comes from metadata bits 27:24 (0 means 16). It then advances the pointer by n and returns status 0.
- R8: Table read (0x24) takes a dword address from metadata bits 14:2 and a count from bits 19:15, where 0 means 16. Entry i holds (i*0x00010003) xor 0xC3A50000. A count above 16, or a span past ROM_DWORDS, returns status 1 and leaves the window unchanged.
- R9: Sector size (0x25) returns status 0 and places SECTOR_BYTES in metadata bits 23:0 with bits 31:24 zero.
- R10: Authenticate (0x21) returns status 0 when stored dword 0 equals AUTH_MAGIC and status 1 (invalid image) otherwise.
- R11: The resource operations read the adapter number from metadata bits 5:0. Query (0x10) returns 0 when the resource is free and 1 when it is held. Allocate (0x11) claims a free resource with status 0 and returns 1 if it is already held. Release (0x12) returns 0 and frees the resource, except when a different adapter holds it: then it returns 1 and the holder stays.
- R12: While an operation is pending, bus writes to any register are ignored. This includes a write on the cycle the operation completes, so the operation's result wins. The first write after completion takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |

## Verification
A register write from the bus and the completion of an operation can land on the same clock edge, and both may target the metadata or a window dword. The bench starts a sector-size query and then issues BUSY_CYCLES+1 back-to-back metadata writes, so the last one falls exactly on the completion edge. It repeats the pattern with window writes over a read. The later readback must show the operation's result and not the bus data. A further write made after the valid flag has cleared must take effect.

// File: rtl/opmbox_pkg.sv
package opmbox_pkg;
    localparam int MB_WIN    = 16;
    localparam int MB_AW     = 5;
    localparam int MB_ADP_W  = 6;

    localparam logic [MB_AW-1:0] REG_META = 5'd16;
    localparam logic [MB_AW-1:0] REG_CMD  = 5'd17;

    localparam logic [15:0] OPC_DP_QUERY = 16'h0010;
    localparam logic [15:0] OPC_DP_ALLOC = 16'h0011;
    localparam logic [15:0] OPC_DP_FREE  = 16'h0012;
    localparam logic [15:0] OPC_NV_WRITE = 16'h0020;
    localparam logic [15:0] OPC_NV_AUTH  = 16'h0021;
    localparam logic [15:0] OPC_NV_READ  = 16'h0022;
    localparam logic [15:0] OPC_NV_SEEK  = 16'h0023;
    localparam logic [15:0] OPC_TBL_READ = 16'h0024;
    localparam logic [15:0] OPC_NV_SECT  = 16'h0025;

    typedef enum logic [3:0] {
        K_NONE, K_DPQ, K_DPA, K_DPR, K_NWR, K_AUTH, K_NRD, K_SEEK, K_TBL, K_SECT
    } op_kind_e;

    function automatic logic [31:0] tbl_word(input logic [31:0] idx);
        return (idx * 32'h0001_0003) ^ 32'hC3A5_0000;
    endfunction
endpackage

// File: rtl/opmbox_decode.sv
module opmbox_decode
    import opmbox_pkg::*;
#(
    parameter int NVM_DWORDS = 64,
    parameter int ROM_DWORDS = 48,
    parameter int WIN        = MB_WIN
) (
    input  logic [15:0]            opc_i,
    input  logic [31:0]            meta_i,
    input  logic [31:0]            wr_off_i,
    output op_kind_e               kind_o,
    output logic                   known_o,
    output logic [31:0]            base_o,
    output logic [$clog2(WIN)+1:0] cnt_o,
    output logic                   ok_o
);
    localparam int CW = $clog2(WIN) + 2;

    logic [CW-1:0] nv_cnt;
    logic [CW-1:0] tbl_cnt;
    logic [31:0]   nv_off;
    logic [31:0]   tbl_off;

    always_comb begin
        nv_cnt  = (meta_i[27:24] == 4'd0) ? CW'(WIN) : CW'(meta_i[27:24]);
        tbl_cnt = (meta_i[19:15] == 5'd0) ? CW'(WIN) : CW'(meta_i[19:15]);
        nv_off  = {10'd0, meta_i[23:2]};
        tbl_off = {19'd0, meta_i[14:2]};

        unique case (opc_i)
            OPC_DP_QUERY: kind_o = K_DPQ;
            OPC_DP_ALLOC: kind_o = K_DPA;
            OPC_DP_FREE:  kind_o = K_DPR;
            OPC_NV_WRITE: kind_o = K_NWR;
            OPC_NV_AUTH:  kind_o = K_AUTH;
            OPC_NV_READ:  kind_o = K_NRD;
            OPC_NV_SEEK:  kind_o = K_SEEK;
            OPC_TBL_READ: kind_o = K_TBL;
            OPC_NV_SECT:  kind_o = K_SECT;
            default:      kind_o = K_NONE;
        endcase
        known_o = (kind_o != K_NONE);

        base_o = 32'd0;
        cnt_o  = '0;
        ok_o   = 1'b1;
        case (kind_o)
            K_NRD: begin
                base_o = nv_off;
                cnt_o  = nv_cnt;
                ok_o   = (nv_off + 32'(nv_cnt)) <= 32'(NVM_DWORDS);
            end
            K_NWR: begin
                base_o = wr_off_i;
                cnt_o  = nv_cnt;
                ok_o   = (wr_off_i + 32'(nv_cnt)) <= 32'(NVM_DWORDS);
            end
            K_SEEK: begin
                base_o = nv_off;
                ok_o   = nv_off < 32'(NVM_DWORDS);
            end
            K_TBL: begin
                base_o = tbl_off;
                cnt_o  = tbl_cnt;
                ok_o   = (tbl_cnt <= CW'(WIN)) &&
                         ((tbl_off + 32'(tbl_cnt)) <= 32'(ROM_DWORDS));
            end
            default: ;
        endcase
    end

    logic unused_meta;
    assign unused_meta = ^{meta_i[31:28], meta_i[1:0]};
endmodule

// File: rtl/opmbox_table.sv
module opmbox_table
    import opmbox_pkg::*;
#(
    parameter int WIN = MB_WIN
) (
    input  logic [31:0]          base_i,
    output logic [WIN-1:0][31:0] words_o
);
    for (genvar g = 0; g < WIN; g++) begin : g_word
        assign words_o[g] = tbl_word(base_i + 32'(g));
    end
endmodule

// File: rtl/opmbox_dpres.sv
module opmbox_dpres
    import opmbox_pkg::*;
#(
    parameter int ADP_W = MB_ADP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  op_kind_e         kind_i,
    input  logic [ADP_W-1:0] adp_i,
    output logic [3:0]       status_o
);
    typedef struct packed {
        logic             held;
        logic [ADP_W-1:0] owner;
    } res_t;

    res_t q, d;

    always_comb begin
        d        = q;
        status_o = 4'd0;
        case (kind_i)
            K_DPQ: status_o = {3'd0, q.held};
            K_DPA: begin
                status_o = {3'd0, q.held};
                if (exec_i && !q.held) begin
                    d.held  = 1'b1;
                    d.owner = adp_i;
                end
            end
            K_DPR: begin
                status_o = {3'd0, q.held && (q.owner != adp_i)};
                if (exec_i && (!q.held || q.owner == adp_i)) d.held = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_alloc_keeps_holder_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && kind_i == K_DPA && q.held) |=> (q.held && $stable(q.owner)));

    assert_foreign_release_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && kind_i == K_DPR && q.held && q.owner != adp_i) |=> q.held);
endmodule

// File: rtl/opmbox_engine.sv
module opmbox_engine
    import opmbox_pkg::*;
#(
    parameter int          NVM_DWORDS   = 64,
    parameter int          ROM_DWORDS   = 48,
    parameter int          BUSY_CYCLES  = 4,
    parameter int          SECTOR_BYTES = 4096,
    parameter logic [31:0] AUTH_MAGIC   = 32'h4E56_4D31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [MB_AW-1:0] bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata
);
    localparam int WIN    = MB_WIN;
    localparam int WIN_AW = $clog2(WIN);
    localparam int NVM_AW = $clog2(NVM_DWORDS);
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 2);
    localparam int N_W    = WIN_AW + 2;

    typedef struct packed {
        logic [WIN-1:0][31:0]        win;
        logic [NVM_DWORDS-1:0][31:0] nvm;
        logic [31:0]                 meta;
        logic [15:0]                 opc;
        logic                        valid;
        logic                        nsup;
        logic [3:0]                  status;
        logic [CNT_W-1:0]            cnt;
        logic [31:0]                 wr_off;
        logic [31:0]                 rdata;
    } state_t;

    state_t q, d;

    op_kind_e             dec_kind;
    logic                 dec_known;
    logic [31:0]          dec_base;
    logic [N_W-1:0]       dec_n;
    logic                 dec_ok;
    logic [WIN-1:0][31:0] tbl_words;
    logic [3:0]           dp_status;
    logic                 exec;

    assign exec = q.valid && (q.cnt == '0);

    opmbox_decode #(
        .NVM_DWORDS(NVM_DWORDS), .ROM_DWORDS(ROM_DWORDS), .WIN(WIN)
    ) u_decode (
        .opc_i   (q.opc),
        .meta_i  (q.meta),
        .wr_off_i(q.wr_off),
        .kind_o  (dec_kind),
        .known_o (dec_known),
        .base_o  (dec_base),
        .cnt_o   (dec_n),
        .ok_o    (dec_ok)
    );

    opmbox_table #(.WIN(WIN)) u_table (
        .base_i (dec_base),
        .words_o(tbl_words)
    );

    opmbox_dpres #(.ADP_W(MB_ADP_W)) u_dpres (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_i  (exec),
        .kind_i  (dec_kind),
        .adp_i   (q.meta[MB_ADP_W-1:0]),
        .status_o(dp_status)
    );

    always_comb begin
        d = q;

        // register bus: reads always served, writes only while idle
        if (bus_en && !bus_we) begin
            if (bus_addr < MB_AW'(WIN))  d.rdata = q.win[bus_addr[WIN_AW-1:0]];
            else if (bus_addr == REG_META) d.rdata = q.meta;
            else if (bus_addr == REG_CMD)
                d.rdata = {q.valid, q.nsup, 2'b00, q.status, 8'h00, q.opc};
            else d.rdata = 32'd0;
        end
        if (bus_en && bus_we && !q.valid) begin
            if (bus_addr < MB_AW'(WIN)) d.win[bus_addr[WIN_AW-1:0]] = bus_wdata;
            else if (bus_addr == REG_META) d.meta = bus_wdata;
            else if (bus_addr == REG_CMD) begin
                d.opc = bus_wdata[15:0];
                if (bus_wdata[31]) begin
                    d.valid  = 1'b1;
                    d.nsup   = 1'b0;
                    d.status = 4'd0;
                    d.cnt    = CNT_W'(BUSY_CYCLES);
                end
            end
        end

        // busy countdown, then the operation executes in one step
        if (q.valid && q.cnt != '0) d.cnt = q.cnt - 1'b1;
        if (exec) begin
            d.valid  = 1'b0;
            d.nsup   = !dec_known;
            d.status = dec_ok ? 4'd0 : 4'd1;
            case (dec_kind)
                K_NRD: if (dec_ok) begin
                    for (int i = 0; i < WIN; i++)
                        if (i < int'(dec_n))
                            d.win[i] = q.nvm[NVM_AW'(dec_base + 32'(i))];
                end
                K_NWR: if (dec_ok) begin
                    for (int i = 0; i < WIN; i++)
                        if (i < int'(dec_n))
                            d.nvm[NVM_AW'(q.wr_off + 32'(i))] = q.win[i];
                    d.wr_off = q.wr_off + 32'(dec_n);
                end
                K_SEEK: if (dec_ok) d.wr_off = dec_base;
                K_TBL: if (dec_ok) begin
                    for (int i = 0; i < WIN; i++)
                        if (i < int'(dec_n)) d.win[i] = tbl_words[i];
                end
                K_SECT: d.meta = {8'd0, 24'(SECTOR_BYTES)};
                K_AUTH: d.status = (q.nvm[0] == AUTH_MAGIC) ? 4'd0 : 4'd1;
                K_DPQ, K_DPA, K_DPR: d.status = dp_status;
                default: d.status = 4'd0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[30:16];

    assert_valid_held_while_counting_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.cnt != '0) |=> q.valid);

    assert_unknown_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !dec_known) |=> (q.nsup && !q.valid && q.status == 4'd0));

    assert_pointer_moves_only_on_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(q.wr_off));

    assert_store_kept_on_range_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !dec_ok) |=> ($stable(q.nvm) && $stable(q.win) && $stable(q.wr_off)));

    assert_busy_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.cnt != '0 && bus_en && bus_we) |=> ($stable(q.meta) && $stable(q.win)));
endmodule

// File: tb/opmbox_engine_tb.sv
module opmbox_engine_tb;
    import opmbox_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVMD  = 64;
    localparam int ROMD  = 48;
    localparam int BUSY  = 4;
    localparam int SECT  = 4096;
    localparam logic [31:0] MAGIC = 32'h4E56_4D31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int bad = 0;

    logic [31:0] nvm_m [NVMD];
    logic [31:0] win_m [16];
    int unsigned wr_off_m = 0;
    bit          held_m = 0;
    int unsigned owner_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opmbox_engine #(
        .NVM_DWORDS(NVMD), .ROM_DWORDS(ROMD), .BUSY_CYCLES(BUSY),
        .SECTOR_BYTES(SECT), .AUTH_MAGIC(MAGIC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] tbl_exp(input int unsigned i);
        return (32'(i) * 32'h0001_0003) ^ 32'hC3A5_0000;
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic run_op(input logic [15:0] opc, output logic [3:0] st,
                          output bit ns, output int busy_polls);
        logic [31:0] v = '0;
        busy_polls = 0;
        bus_write(REG_CMD, {1'b1, 15'd0, opc});
        for (int k = 0; k < 100; k++) begin
            bus_read(REG_CMD, v);
            if (!v[31]) break;
            busy_polls++;
        end
        st = v[27:24];
        ns = v[30];
    endtask

    task automatic op_expect(input string tag, input logic [15:0] opc,
                             input logic [3:0] exp_st, input bit exp_ns);
        logic [3:0] st; bit ns; int bp;
        run_op(opc, st, ns, bp);
        chk({tag, " status"}, 32'(st), 32'(exp_st));
        chk({tag, " nsup"}, 32'(ns), 32'(exp_ns));
    endtask

    task automatic cmp_window(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            bus_read(5'(i), v);
            chk(tag, v, win_m[i]);
        end
    endtask

    task automatic do_seek(input int unsigned off);
        bit ok = off < NVMD;
        bus_write(REG_META, 32'(off) << 2);
        op_expect("R6 seek", OPC_NV_SEEK, ok ? 4'd0 : 4'd1, 1'b0);
        if (ok) wr_off_m = off;
    endtask

    task automatic do_write(input int unsigned c);
        int unsigned n = (c == 0) ? 16 : c;
        bit ok = (wr_off_m + n) <= NVMD;
        bus_write(REG_META, 32'(c) << 24);
        op_expect(ok ? "R7 write" : "R5 write range", OPC_NV_WRITE, ok ? 4'd0 : 4'd1, 1'b0);
        if (ok) begin
            for (int i = 0; i < int'(n); i++) nvm_m[wr_off_m + i] = win_m[i];
            wr_off_m += n;
        end
    endtask

    task automatic do_read(input int unsigned off, input int unsigned c);
        int unsigned n = (c == 0) ? 16 : c;
        bit ok = (off + n) <= NVMD;
        bus_write(REG_META, (32'(c) << 24) | (32'(off) << 2));
        op_expect(ok ? "R4 read" : "R5 read range", OPC_NV_READ, ok ? 4'd0 : 4'd1, 1'b0);
        if (ok) for (int i = 0; i < int'(n); i++) win_m[i] = nvm_m[off + i];
        cmp_window(ok ? "R4 window" : "R5 window kept");
    endtask

    task automatic do_tbl(input int unsigned a, input int unsigned c);
        int unsigned n = (c == 0) ? 16 : c;
        bit ok = (n <= 16) && ((a + n) <= ROMD);
        bus_write(REG_META, (32'(c) << 15) | (32'(a) << 2));
        op_expect("R8 table", OPC_TBL_READ, ok ? 4'd0 : 4'd1, 1'b0);
        if (ok) for (int i = 0; i < int'(n); i++) win_m[i] = tbl_exp(a + i);
        cmp_window("R8 window");
    endtask

    task automatic do_dp(input int unsigned k, input int unsigned adp);
        logic [3:0] e;
        bus_write(REG_META, 32'(adp));
        case (k)
            0: begin e = {3'd0, held_m};
                op_expect("R11 query", OPC_DP_QUERY, e, 1'b0); end
            1: begin e = {3'd0, held_m};
                op_expect("R11 alloc", OPC_DP_ALLOC, e, 1'b0);
                if (!held_m) begin held_m = 1; owner_m = adp; end end
            default: begin e = {3'd0, held_m && owner_m != adp};
                op_expect("R11 release", OPC_DP_FREE, e, 1'b0);
                if (e == 0) held_m = 0; end
        endcase
    endtask

    task automatic fill_window();
        for (int i = 0; i < 16; i++) begin
            logic [31:0] r = $urandom;
            bus_write(5'(i), r);
            win_m[i] = r;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [3:0] st; bit ns; int bp;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NVMD; i++) nvm_m[i] = '0;
        for (int i = 0; i < 16; i++) win_m[i] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        bus_read(REG_CMD, v);  chk("R1 cmd", v, 32'd0);
        bus_read(REG_META, v); chk("R1 meta", v, 32'd0);
        cmp_window("R1 window");

        // R2 / R3 handshake and unknown opcode
        run_op(16'h0013, st, ns, bp);
        chk("R2 busy polls", 32'(bp), 32'(BUSY + 1));
        chk("R3 unknown nsup", 32'(ns), 32'd1);
        chk("R3 unknown status", 32'(st), 32'd0);
        bus_read(REG_CMD, v);
        chk("R2 cmd layout", v, {1'b0, 1'b1, 2'b00, 4'd0, 8'd0, 16'h0013});
        op_expect("R3 unknown 0x26", 16'h0026, 4'd0, 1'b1);

        // R9 sector size
        bus_write(REG_META, 32'hFFFF_FFFF);
        op_expect("R9 sector", OPC_NV_SECT, 4'd0, 1'b0);
        bus_read(REG_META, v); chk("R9 meta", v, 32'(SECT));

        // R10 authenticate
        op_expect("R10 bad image", OPC_NV_AUTH, 4'd1, 1'b0);
        do_seek(0);
        bus_write(5'd0, MAGIC); win_m[0] = MAGIC;
        do_write(1);
        op_expect("R10 good image", OPC_NV_AUTH, 4'd0, 1'b0);

        // R12 bus writes colliding with completion
        bus_write(REG_META, 32'd0);
        bus_write(REG_CMD, {1'b1, 15'd0, OPC_NV_SECT});
        for (int k = 0; k < BUSY + 1; k++) bus_write(REG_META, 32'hDEAD_BEEF);
        bus_read(REG_META, v); chk("R12 result wins", v, 32'(SECT));
        bus_write(REG_META, 32'h1234_5678);
        bus_read(REG_META, v); chk("R12 write after done", v, 32'h1234_5678);
        bus_write(REG_META, (32'd2 << 24) | (32'd0 << 2));
        bus_write(REG_CMD, {1'b1, 15'd0, OPC_NV_READ});
        for (int k = 0; k < BUSY + 1; k++) bus_write(5'd1, 32'hBAD0_0001);
        win_m[0] = nvm_m[0]; win_m[1] = nvm_m[1];
        bus_read(5'd1, v); chk("R12 window result wins", v, win_m[1]);
        bus_read(REG_CMD, v); chk("R12 read done", 32'(v[31]), 32'd0);

        // R11 resource
        do_dp(0, 3); do_dp(1, 3); do_dp(1, 5); do_dp(0, 5);
        do_dp(2, 5); do_dp(2, 3); do_dp(0, 3);

        // R4 / R5 / R6 / R7 / R8 boundaries
        do_seek(48); fill_window(); do_write(0);
        do_read(60, 4); do_read(61, 4); do_read(48, 0);
        do_seek(64); do_seek(63); do_write(2); do_write(1);
        do_tbl(32, 0); do_tbl(33, 0); do_tbl(0, 17); do_tbl(47, 1);

        // constrained random mix
        for (int it = 0; it < 80; it++) begin
            int unsigned k = $urandom % 6;
            case (k)
                0: do_seek($urandom % 70);
                1: begin fill_window(); do_write($urandom % 16); end
                2: do_read($urandom % 70, $urandom % 16);
                3: do_tbl($urandom % 56, $urandom % 20);
                4: do_dp($urandom % 3, $urandom % 4);
                default: op_expect("R3 random unknown", 16'(16'h0030 + ($urandom % 8)), 4'd0, 1'b1);
            endcase
        end
        op_expect("R10 final auth", OPC_NV_AUTH, (nvm_m[0] == MAGIC) ? 4'd0 : 4'd1, 1'b0);

        summary();
        $finish;
    end
endmodule